// File: doc/BRIEF.md
# SPI NOR Flash Command Responder

This block is the target side of a SPI NOR flash in clock mode 0, with a small on-chip byte array in place of the flash cells. It runs on a fast system clock and oversamples the serial pins. MOSI is captured at each rising SCK edge while chip select is low. The first byte of a frame is the opcode, and a 24-bit big-endian address follows it where the command needs one. Read data leaves on MISO after each falling SCK edge. MISO comes with an output-enable pin, so a board-level tri-state buffer can sit outside the block.

Four commands are understood. Write enable arms a latch. Sector erase and page program are held back until chip select rises, and they only take effect if that latch is set. Program behaves like real NOR cells: bits can only go from one to zero. Read streams bytes from any address for as long as chip select stays low. Erase and program run in a short internal engine that walks the array one byte per clock. Any frame that begins while the engine runs is dropped.

Top module: `spi_flash_responder`

## Requirements
- R1: When the synchronous active-high reset is held, miso and miso_en read 0 and the write-enable latch is cleared. A write enable sent before a reset therefore does not let a later program take effect.
- R2: Frame bits are taken from mosi on rising sck edges while cs_n is low, most significant bit first. Byte 0 is the opcode and bytes 1..3 are a 24-bit address. Only the address modulo MEM_BYTES is used, so the upper address bits are ignored.
- R3: A frame holding exactly the 8 bits of opcode 0x06 sets the write-enable latch when cs_n rises. The same opcode in a frame of any other length leaves the latch unchanged.
- R4: Opcode 0xD8 in a frame of exactly 32 bits, sent with the latch set, fills every byte of the SECTOR_BYTES-aligned sector holding the address with 0xFF. Bytes outside that sector are untouched.
- R5: Opcode 0x02 in a frame of at least 40 bits and a whole number of bytes, sent with the latch set, stores (old AND new) for each data byte. Nothing changes in the array before cs_n rises.
- R6: Program data bytes go to consecutive addresses that wrap inside the PAGE_BYTES-aligned page of the start address.
- R7: Erase or program with the latch clear has no effect. A committed erase or program clears the latch, so a second program without a fresh write enable is discarded.
- R8: An erase or program frame that ends off a byte boundary, or before its address is complete, is discarded, and the latch keeps its value.
- R9: Opcode 0x03 followed by a 24-bit address makes miso carry the byte at that address, MSB first, one bit per falling sck edge from the edge after the 32nd rising edge. The address then increments and wraps at the end of the array.
- R10: miso_en is 1 only in the data phase of a read frame. It is 0 within four clocks of cs_n being high, and it never rises in other frames.
- R11: A frame whose opcode is not one of the four is ignored until cs_n next rises. It changes neither the array nor the latch, and it never enables miso.
- R12: A frame that starts while an erase or program is still being applied is ignored completely, including a write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be at least 8x the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host, idles low (mode 0) |
| cs_n | input | 1 | Active-low chip select; frame boundaries |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read data, registered |
| miso_en | output | 1 | Drive enable for miso, registered |

## Verification
A wrong bit or byte counter shows up at the ports as a shifted read stream: the first data bit after the address phase is already wrong, within one SCK period of the data phase starting. A lost or stuck write-enable latch, a wrong commit decision, or a bad sector or page base does not show up until the next read of the affected bytes. For that reason the bench follows every erase and program with reads that cover the target bytes, page-wrap neighbours and bytes just outside the sector. miso_en is compared on every clock while chip select is high, and at every sampling point in read and unknown-opcode frames.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ERASE = 8'hD8;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ERASE,
    ENG_PROG,
    ENG_DRAIN
  } eng_state_t;

  function automatic logic opcode_known(input logic [7:0] op);
    return (op == OP_WREN) || (op == OP_ERASE) || (op == OP_PROG) || (op == OP_READ);
  endfunction
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_low,
  output logic mosi_s
);
  logic [STAGES:0]   sck_q;
  logic [STAGES:0]   cs_q;
  logic [STAGES-1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[STAGES-1:0], sck_i};
      cs_q   <= {cs_q[STAGES-1:0], cs_n_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sck_fall = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign cs_fall  = ~cs_q[STAGES-1] & cs_q[STAGES];
  assign cs_rise  = cs_q[STAGES-1] & ~cs_q[STAGES];
  assign cs_low   = ~cs_q[STAGES-1];
  assign mosi_s   = mosi_q[STAGES-1];
endmodule

// File: rtl/sfr_ram.sv
module sfr_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/sfr_frame.sv
module sfr_frame
  import sfr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic                  cs_fall,
  input  logic                  cs_rise,
  input  logic                  cs_low,
  input  logic                  mosi_s,
  input  logic                  busy,
  input  logic [7:0]            mem_rdata,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic                  pbuf_we,
  output logic [PAGE_W-1:0]     pbuf_waddr,
  output logic [7:0]            pbuf_wdata,
  output logic [PAGE_BYTES-1:0] pbuf_mask,
  output logic                  start_erase,
  output logic                  start_prog,
  output logic [ADDR_W-1:0]     cmd_addr,
  output logic                  wel,
  output logic                  miso,
  output logic                  miso_en
);
  logic              ignore_q;
  logic [2:0]        bit_q;
  logic [2:0]        byte_q;
  logic [6:0]        sh_q;
  logic [7:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_phase_q;
  logic [2:0]        obit_q;
  logic [6:0]        osh_q;
  logic [PAGE_W-1:0] woff_q;

  logic [7:0]        byte_in;
  logic [ADDR_W-1:0] new_addr;
  logic              whole_bytes;

  assign byte_in     = {sh_q, mosi_s};
  assign new_addr    = ADDR_W'({addr_q, byte_in});
  assign whole_bytes = (bit_q == 3'd0);
  assign cmd_addr    = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ignore_q    <= 1'b1;
      bit_q       <= '0;
      byte_q      <= '0;
      sh_q        <= '0;
      op_q        <= '0;
      addr_q      <= '0;
      rd_phase_q  <= 1'b0;
      obit_q      <= '0;
      osh_q       <= '0;
      woff_q      <= '0;
      rd_addr     <= '0;
      pbuf_we     <= 1'b0;
      pbuf_waddr  <= '0;
      pbuf_wdata  <= '0;
      pbuf_mask   <= '0;
      start_erase <= 1'b0;
      start_prog  <= 1'b0;
      wel         <= 1'b0;
      miso        <= 1'b0;
      miso_en     <= 1'b0;
    end else begin
      start_erase <= 1'b0;
      start_prog  <= 1'b0;
      pbuf_we     <= 1'b0;
      if (cs_fall) begin
        ignore_q   <= busy;
        bit_q      <= '0;
        byte_q     <= '0;
        op_q       <= '0;
        rd_phase_q <= 1'b0;
        obit_q     <= '0;
        miso_en    <= 1'b0;
        if (!busy) pbuf_mask <= '0;
      end else if (cs_rise) begin
        ignore_q   <= 1'b1;
        rd_phase_q <= 1'b0;
        miso_en    <= 1'b0;
        miso       <= 1'b0;
        if (!ignore_q && whole_bytes) begin
          if (op_q == OP_WREN && byte_q == 3'd1) wel <= 1'b1;
          if (op_q == OP_ERASE && byte_q == 3'd4 && wel) begin
            start_erase <= 1'b1;
            wel         <= 1'b0;
          end
          if (op_q == OP_PROG && byte_q >= 3'd5 && wel) begin
            start_prog <= 1'b1;
            wel        <= 1'b0;
          end
        end
      end else if (cs_low && !ignore_q) begin
        if (sck_rise) begin
          sh_q  <= byte_in[6:0];
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            if (byte_q != 3'd7) byte_q <= byte_q + 3'd1;
            if (byte_q == 3'd0) begin
              op_q <= byte_in;
              if (!opcode_known(byte_in)) ignore_q <= 1'b1;
            end else if (byte_q <= 3'd3) begin
              addr_q <= new_addr;
              if (byte_q == 3'd3) begin
                woff_q <= new_addr[PAGE_W-1:0];
                if (op_q == OP_READ) begin
                  rd_phase_q <= 1'b1;
                  rd_addr    <= new_addr;
                end
              end
            end else if (op_q == OP_PROG) begin
              pbuf_we           <= 1'b1;
              pbuf_waddr        <= woff_q;
              pbuf_wdata        <= byte_in;
              pbuf_mask[woff_q] <= 1'b1;
              woff_q            <= woff_q + 1'b1;
            end
          end
        end
        if (sck_fall && rd_phase_q) begin
          miso_en <= 1'b1;
          obit_q  <= obit_q + 3'd1;
          if (obit_q == 3'd0) begin
            miso    <= mem_rdata[7];
            osh_q   <= mem_rdata[6:0];
            rd_addr <= rd_addr + 1'b1;
          end else begin
            miso  <= osh_q[6];
            osh_q <= {osh_q[5:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfr_commit.sv
module sfr_commit
  import sfr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SECTOR_W = 9,
  parameter int PAGE_W   = 8,
  localparam int PAGE_BYTES   = 1 << PAGE_W,
  localparam int SECTOR_BYTES = 1 << SECTOR_W,
  localparam int IDX_W = (SECTOR_W > PAGE_W) ? SECTOR_W : PAGE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_erase,
  input  logic                  start_prog,
  input  logic [ADDR_W-1:0]     base,
  input  logic [PAGE_BYTES-1:0] mask,
  input  logic [7:0]            mem_rdata,
  input  logic [7:0]            pbuf_rdata,
  output logic                  busy,
  output logic [ADDR_W-1:0]     mem_raddr,
  output logic [PAGE_W-1:0]     pbuf_raddr,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_waddr,
  output logic [7:0]            mem_wdata
);
  localparam logic [ADDR_W-1:0] SECTOR_ALIGN = ~ADDR_W'(SECTOR_BYTES - 1);
  localparam logic [ADDR_W-1:0] PAGE_ALIGN   = ~ADDR_W'(PAGE_BYTES - 1);

  eng_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PAGE_W-1:0] idx_d_q;
  logic              vld_q;
  logic [ADDR_W-1:0] region_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ENG_IDLE;
      idx_q    <= '0;
      idx_d_q  <= '0;
      vld_q    <= 1'b0;
      region_q <= '0;
    end else begin
      vld_q <= 1'b0;
      case (state_q)
        ENG_IDLE: begin
          idx_q <= '0;
          if (start_erase) begin
            region_q <= base & SECTOR_ALIGN;
            state_q  <= ENG_ERASE;
          end else if (start_prog) begin
            region_q <= base & PAGE_ALIGN;
            state_q  <= ENG_PROG;
          end
        end
        ENG_ERASE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(SECTOR_BYTES - 1)) state_q <= ENG_IDLE;
        end
        ENG_PROG: begin
          vld_q   <= 1'b1;
          idx_d_q <= idx_q[PAGE_W-1:0];
          idx_q   <= idx_q + 1'b1;
          if (idx_q == IDX_W'(PAGE_BYTES - 1)) state_q <= ENG_DRAIN;
        end
        ENG_DRAIN: state_q <= ENG_IDLE;
        default:   state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ENG_IDLE);
  assign mem_raddr  = region_q + ADDR_W'(idx_q);
  assign pbuf_raddr = idx_q[PAGE_W-1:0];

  always_comb begin
    if (state_q == ENG_ERASE) begin
      mem_we    = 1'b1;
      mem_waddr = region_q + ADDR_W'(idx_q);
      mem_wdata = 8'hFF;
    end else begin
      mem_we    = vld_q & mask[idx_d_q];
      mem_waddr = region_q + ADDR_W'(idx_d_q);
      mem_wdata = mem_rdata & pbuf_rdata;
    end
  end
endmodule

// File: rtl/spi_flash_responder.sv
module spi_flash_responder #(
  parameter int MEM_BYTES    = 1024,
  parameter int SECTOR_BYTES = 512,
  parameter int PAGE_BYTES   = 256,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_en
);
  localparam int ADDR_W   = $clog2(MEM_BYTES);
  localparam int SECTOR_W = $clog2(SECTOR_BYTES);
  localparam int PAGE_W   = $clog2(PAGE_BYTES);

  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_low, mosi_s;
  logic eng_busy, start_erase, start_prog, wel;
  logic pbuf_we;
  logic [PAGE_W-1:0]     pbuf_waddr, pbuf_raddr;
  logic [7:0]            pbuf_wdata, pbuf_rdata;
  logic [PAGE_BYTES-1:0] pbuf_mask;
  logic [ADDR_W-1:0]     rd_addr, cmd_addr, eng_raddr, mem_raddr, mem_waddr;
  logic [7:0]            mem_rdata, mem_wdata;
  logic                  mem_we;

  sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_low(cs_low), .mosi_s(mosi_s)
  );

  sfr_frame #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_frame (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_low(cs_low), .mosi_s(mosi_s),
    .busy(eng_busy), .mem_rdata(mem_rdata), .rd_addr(rd_addr),
    .pbuf_we(pbuf_we), .pbuf_waddr(pbuf_waddr), .pbuf_wdata(pbuf_wdata),
    .pbuf_mask(pbuf_mask), .start_erase(start_erase), .start_prog(start_prog),
    .cmd_addr(cmd_addr), .wel(wel), .miso(miso), .miso_en(miso_en)
  );

  sfr_commit #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .PAGE_W(PAGE_W)) u_commit (
    .clk(clk), .rst(rst), .start_erase(start_erase), .start_prog(start_prog),
    .base(cmd_addr), .mask(pbuf_mask), .mem_rdata(mem_rdata),
    .pbuf_rdata(pbuf_rdata), .busy(eng_busy), .mem_raddr(eng_raddr),
    .pbuf_raddr(pbuf_raddr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  assign mem_raddr = eng_busy ? eng_raddr : rd_addr;

  sfr_ram #(.DEPTH(MEM_BYTES), .WIDTH(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  sfr_ram #(.DEPTH(PAGE_BYTES), .WIDTH(8)) u_pagebuf (
    .clk(clk), .we(pbuf_we), .waddr(pbuf_waddr), .wdata(pbuf_wdata),
    .raddr(pbuf_raddr), .rdata(pbuf_rdata)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic miso_en,
  input logic busy,
  input logic start_erase,
  input logic start_prog,
  input logic wel,
  input logic pbuf_we
);
  // R10: output stays off once select has been high for four samples
  p_quiet_deselected_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_en);

  // R10: output turns on only while select has been low
  p_enable_under_select_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(miso_en) |-> (!$past(cs_n, 3) && !cs_n));

  // R7: commits are decided only after select has gone high
  p_commit_after_deselect_r7: assert property (@(posedge clk) disable iff (rst)
    (start_erase || start_prog) |-> $past(cs_n, 2));

  // R7: a commit consumes an armed latch
  p_latch_consumed_r7: assert property (@(posedge clk) disable iff (rst)
    (start_erase || start_prog) |-> ($past(wel) && !wel));

  // R4: the engine picks up every commit on the next clock
  p_engine_runs_r4: assert property (@(posedge clk) disable iff (rst)
    (start_erase || start_prog) |=> busy);

  // R12: no commit is requested while the engine is running
  p_no_commit_busy_r12: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(start_erase || start_prog));

  // R12: page buffer is frozen while the engine reads it
  p_buffer_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pbuf_we);

  p_one_commit_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_erase, start_prog}));
endmodule

bind spi_flash_responder sfr_checker u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .miso_en(miso_en), .busy(eng_busy),
  .start_erase(start_erase), .start_prog(start_prog), .wel(wel),
  .pbuf_we(pbuf_we)
);

// File: tb/spi_flash_responder_tb.sv
`timescale 1ns/1ps
module spi_flash_responder_tb;
  localparam int MEM  = 1024;
  localparam int SEC  = 512;
  localparam int PG   = 256;
  localparam int HALF = 8;
  localparam int LONG = SEC + 60;
  localparam int SHORT = 40;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_en;

  int total = 0, bad = 0;
  longint cyc = 0;
  int hi_cnt = 0;

  logic [7:0] mm [MEM];
  bit wel_m = 0;
  longint busy_until = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_flash_responder #(.MEM_BYTES(MEM), .SECTOR_BYTES(SEC), .PAGE_BYTES(PG)) u_dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_en(miso_en)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock check of the output enable while deselected (R10)
  always @(negedge clk) begin
    if (rst) hi_cnt = 0;
    else begin
      if (cs_n) hi_cnt++; else hi_cnt = 0;
      if (hi_cnt >= 5) chk("R10", "miso_en while deselected", int'(miso_en), 0);
    end
  end

  task automatic frame(input logic [7:0] b[$], input int nbits, input int nrd,
                       input int gap, input string req);
    bit ign;
    logic [7:0] op;
    int a, base, off;
    logic [7:0] exp_rd[$];
    ign = (cyc < busy_until);
    op  = (b.size() > 0) ? b[0] : 8'h00;
    a   = (b.size() >= 4) ? int'({b[1], b[2], b[3]}) % MEM : 0;
    for (int k = 0; k < nrd; k++) exp_rd.push_back(mm[(a + k) % MEM]);
    tick(1);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits + 8 * nrd; i++) begin
      if (i < nbits) mosi = b[i / 8][7 - (i % 8)];
      else mosi = 1'b0;
      tick(HALF);
      if (i >= 32 && nrd > 0 && !ign && op == 8'h03 && nbits == 32) begin
        chk(req, "read bit", int'(miso), int'(exp_rd[(i - 32) / 8][7 - ((i - 32) % 8)]));
        chk("R10", "miso_en in read data", int'(miso_en), 1);
      end
      if (op == 8'h9F) chk("R11", "miso_en in unknown frame", int'(miso_en), 0);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    if (!ign && nbits >= 8) begin
      if (op == 8'h06 && nbits == 8) wel_m = 1;
      if (op == 8'hD8 && nbits == 32 && wel_m) begin
        base = a - (a % SEC);
        for (int k = 0; k < SEC; k++) mm[base + k] = 8'hFF;
        wel_m = 0;
        busy_until = cyc + SEC + 10;
      end
      if (op == 8'h02 && nbits >= 40 && nbits % 8 == 0 && wel_m) begin
        base = a - (a % PG);
        off  = a % PG;
        for (int k = 0; k < nbits / 8 - 4; k++)
          mm[base + (off + k) % PG] = mm[base + (off + k) % PG] & b[4 + k];
        wel_m = 0;
        busy_until = cyc + PG + 10;
      end
    end
    tick(gap);
  endtask

  task automatic rd(input int addr, input int n, input string req);
    frame('{8'h03, addr[23:16], addr[15:8], addr[7:0]}, 32, n, SHORT, req);
  endtask

  task automatic wren();
    frame('{8'h06}, 8, 0, SHORT, "R3");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    tick(6);
    // R1: outputs are low in reset
    chk("R1", "miso in reset", int'(miso), 0);
    chk("R1", "miso_en in reset", int'(miso_en), 0);
    rst = 1'b0;
    tick(10);

    // set up both sectors and a marker byte in sector 1 (R4)
    wren(); frame('{8'hD8, 8'h00, 8'h00, 8'h00}, 32, 0, LONG, "R4");
    wren(); frame('{8'hD8, 8'h00, 8'h02, 8'h00}, 32, 0, LONG, "R4");
    rd(32'h10, 4, "R4");
    wren(); frame('{8'h02, 8'h00, 8'h03, 8'h00, 8'h77}, 40, 0, LONG, "R5");

    // R5: two-byte program then readback around it (R9)
    wren(); frame('{8'h02, 8'h00, 8'h00, 8'h10, 8'h0F, 8'hA5}, 48, 0, LONG, "R5");
    rd(32'h0F, 4, "R9");

    // R7: program without write enable is discarded
    frame('{8'h02, 8'h00, 8'h00, 8'h10, 8'h00}, 40, 0, LONG, "R7");
    rd(32'h10, 1, "R7");

    // R5: AND with stored value
    wren(); frame('{8'h02, 8'h00, 8'h00, 8'h10, 8'hF0}, 40, 0, LONG, "R5");
    rd(32'h10, 2, "R5");

    // R6: wrap inside the page
    wren(); frame('{8'h02, 8'h00, 8'h00, 8'hFE, 8'h11, 8'h22, 8'h33, 8'h44}, 64, 0, LONG, "R6");
    rd(32'hFE, 3, "R6");
    rd(32'h00, 2, "R6");

    // R9: read wraps at array end; R2: upper address bits ignored
    rd(32'h3FF, 2, "R9");
    rd(32'hFF0001, 1, "R2");

    // R8: truncated program keeps the latch, a later full one uses it
    wren(); frame('{8'h02, 8'h00, 8'h00, 8'h20, 8'hAB}, 39, 0, LONG, "R8");
    frame('{8'h02, 8'h00, 8'h00, 8'h20, 8'hAB}, 40, 0, LONG, "R8");
    rd(32'h20, 1, "R8");
    wren(); frame('{8'hD8, 8'h00, 8'h00, 8'h00}, 24, 0, LONG, "R8");
    frame('{8'hD8, 8'h00, 8'h00, 8'h00}, 32, 0, LONG, "R8");
    rd(32'h20, 1, "R4");
    rd(32'hFE, 2, "R4");
    rd(32'h300, 1, "R4");

    // R3: write enable of the wrong length does not arm
    frame('{8'h06, 8'h00}, 9, 0, SHORT, "R3");
    frame('{8'h02, 8'h00, 8'h00, 8'h30, 8'h55}, 40, 0, LONG, "R3");
    rd(32'h30, 1, "R3");

    // R11: unknown opcode leaves the latch and array alone
    wren();
    frame('{8'h9F, 8'h02, 8'h00, 8'h00, 8'h31, 8'h00}, 48, 0, LONG, "R11");
    rd(32'h31, 1, "R11");
    frame('{8'h02, 8'h00, 8'h00, 8'h30, 8'h55}, 40, 0, LONG, "R11");
    rd(32'h30, 2, "R11");

    // R12: write enable during a running erase is dropped
    wren(); frame('{8'hD8, 8'h00, 8'h02, 8'h00}, 32, 0, 20, "R12");
    wren();
    tick(LONG);
    frame('{8'h02, 8'h00, 8'h02, 8'h10, 8'h00}, 40, 0, LONG, "R12");
    rd(32'h210, 1, "R12");

    // R1: reset clears the latch
    wren();
    rst = 1'b1; tick(4); rst = 1'b0; wel_m = 0; tick(10);
    frame('{8'h02, 8'h00, 8'h00, 8'h40, 8'h12}, 40, 0, LONG, "R1");
    rd(32'h40, 1, "R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule